// File: doc/BRIEF.md
# Branch Squash and Redirect Controller

This block is the control logic that settles conditional branches and jumps in a five-stage in-order pipeline. A branch resolves in the memory stage. That stage supplies the opcode, a valid bit, the equality result of the register compare, the branch PC and its signed offset. From these the block drives a fetch redirect, which is a valid strobe and a target. It also drives squash strobes that turn younger instructions into no-ops, a fetch hold, a decode bubble and a gated data-hazard stall.

The parameter `SPECULATE` chooses one of two policies. With `SPECULATE=1`, every branch is assumed not taken and fetch keeps going along the sequential path. A taken branch squashes the fetch, decode and execute stages in the same cycle that it resolves. With `SPECULATE=0`, a branch or jump seen in decode holds fetch and feeds no-ops into decode until the branch resolves. Only the sequentially fetched instruction then needs to be squashed. In both modes the fetch PC loads the target on the clock edge that ends the resolve cycle.

Top module: `branchRedirectCtl`

## Requirements
- R1: In speculative mode, a valid conditional branch (opcode 3'd4) with `memEqual=0` produces no redirect, no squash and no fetch hold. A not-taken branch costs no cycles.
- R2: In speculative mode, a taken branch raises `redirectValid`, `squashFetch`, `squashDecode` and `squashExecute` together, in the cycle it is presented in the memory stage.
- R3: `redirectTarget` equals `memPc + 1 + sign-extended memOffset`, modulo 2^PC_W, whenever `redirectValid` is high.
- R4: A jump (opcode 3'd5) is taken whatever `memEqual` is. A conditional branch (opcode 3'd4) is taken exactly when `memEqual=1`, so comparing a register with itself always redirects.
- R5: When `memValid=0`, or the memory-stage opcode is neither 3'd4 nor 3'd5, there is no redirect and no squash, and `redirectTarget` is zero.
- R6: A squash has priority over a data-hazard stall. In a redirect cycle `pipeStall` and `fetchHold` are 0. Without a squash, `pipeStall` follows `hazardStall`.
- R7: In stall mode, a valid branch or jump in decode raises `fetchHold` and `decodeBubble`. Both stay high until the cycle the branch resolves in the memory stage, and both are low in that cycle.
- R8: In stall mode, a taken branch raises `redirectValid` and `squashFetch` only. `squashDecode` and `squashExecute` stay 0.
- R9: After reset with idle inputs, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode stage holds a real instruction |
| decOp | input | 3 | Decode stage opcode |
| memValid | input | 1 | Memory stage holds a real (not squashed) instruction |
| memOp | input | 3 | Memory stage opcode |
| memEqual | input | 1 | Register compare result of the resolving branch |
| memPc | input | PC_W | PC of the resolving instruction |
| memOffset | input | OFS_W | Signed branch offset |
| hazardStall | input | 1 | Data-hazard stall request |
| redirectValid | output | 1 | Load fetch PC with target at the next edge |
| redirectTarget | output | PC_W | Redirect target, zero when not redirecting |
| squashFetch | output | 1 | Turn the fetch-stage instruction into a no-op |
| squashDecode | output | 1 | Turn the decode-stage instruction into a no-op |
| squashExecute | output | 1 | Turn the execute-stage instruction into a no-op |
| fetchHold | output | 1 | Hold the fetch PC and instruction |
| decodeBubble | output | 1 | Pass a no-op into decode |
| pipeStall | output | 1 | Gated data-hazard stall |

## Verification
The assertions check on every cycle that squashes come with a redirect and that a redirect never coexists with a stall or hold. They also check that an invalid memory stage never redirects, that jumps always redirect, that the target is zero outside a redirect, that a decode bubble implies a fetch hold, and that stall mode never squashes decode or execute. The arithmetic of the target (including wrap and negative offsets), the exact length of the stall-mode hold window, the release in the resolve cycle and the reset state can only be shown by the bench's directed scenarios.

// File: rtl/brCtlPkg.sv
package brCtlPkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_BEQ = 3'd4;
  localparam logic [OP_W-1:0] OP_JMP = 3'd5;

  typedef struct packed {
    logic redirect;
    logic sqFetch;
    logic sqDecode;
    logic sqExecute;
    logic fetchHold;
    logic decBubble;
    logic pipeStall;
  } ctlStrobeT;
endpackage

// File: rtl/brCtlControl.sv
module brCtlControl
  import brCtlPkg::*;
#(
  parameter int SPECULATE = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            decValid,
  input  logic [OP_W-1:0] decOp,
  input  logic            memValid,
  input  logic [OP_W-1:0] memOp,
  input  logic            memEqual,
  input  logic            hazardStall,
  output ctlStrobeT       strobe
);
  logic decIsBr, memIsBr, memIsJmp, taken, resolveNow;
  logic pending, brHold, stallGated;

  assign decIsBr    = decValid && ((decOp == OP_BEQ) || (decOp == OP_JMP));
  assign memIsJmp   = memOp == OP_JMP;
  assign memIsBr    = memValid && ((memOp == OP_BEQ) || memIsJmp);
  assign taken      = memIsBr && (memIsJmp || memEqual);
  assign resolveNow = memIsBr;

  // Stall-mode window: set when a branch leaves decode, cleared at resolve.
  always_ff @(posedge clk) begin
    if (!rstN || SPECULATE != 0) begin
      pending <= 1'b0;
    end else if (resolveNow) begin
      pending <= 1'b0;
    end else if (decIsBr && !hazardStall) begin
      pending <= 1'b1;
    end
  end

  assign brHold     = (SPECULATE != 0) ? 1'b0 : ((decIsBr || pending) && !resolveNow);
  assign stallGated = hazardStall && !taken;

  generate
    if (SPECULATE != 0) begin : gSpec
      always_comb begin
        strobe           = '0;
        strobe.redirect  = taken;
        strobe.sqFetch   = taken;
        strobe.sqDecode  = taken;
        strobe.sqExecute = taken;
        strobe.pipeStall = stallGated;
        strobe.fetchHold = stallGated;
        strobe.decBubble = 1'b0;
      end
    end else begin : gStall
      always_comb begin
        strobe           = '0;
        strobe.redirect  = taken;
        strobe.sqFetch   = taken;
        strobe.sqDecode  = 1'b0;
        strobe.sqExecute = 1'b0;
        strobe.pipeStall = stallGated;
        strobe.fetchHold = brHold || stallGated;
        strobe.decBubble = brHold && !stallGated;
      end
    end
  endgenerate
endmodule

// File: rtl/brCtlDatapath.sv
module brCtlDatapath
  import brCtlPkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8
) (
  input  logic [PC_W-1:0]  memPc,
  input  logic [OFS_W-1:0] memOffset,
  input  ctlStrobeT        strobe,
  output logic [PC_W-1:0]  redirectTarget
);
  localparam int EXT_W = PC_W - OFS_W;
  logic [PC_W-1:0] offsetExt, targetSum;

  assign offsetExt      = {{EXT_W{memOffset[OFS_W-1]}}, memOffset};
  assign targetSum      = memPc + {{(PC_W-1){1'b0}}, 1'b1} + offsetExt;
  assign redirectTarget = strobe.redirect ? targetSum : '0;
endmodule

// File: rtl/branchRedirectCtl.sv
module branchRedirectCtl
  import brCtlPkg::*;
#(
  parameter int PC_W      = 16,
  parameter int OFS_W     = 8,
  parameter int SPECULATE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic [2:0]       decOp,
  input  logic             memValid,
  input  logic [2:0]       memOp,
  input  logic             memEqual,
  input  logic [PC_W-1:0]  memPc,
  input  logic [OFS_W-1:0] memOffset,
  input  logic             hazardStall,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectTarget,
  output logic             squashFetch,
  output logic             squashDecode,
  output logic             squashExecute,
  output logic             fetchHold,
  output logic             decodeBubble,
  output logic             pipeStall
);
  ctlStrobeT strobe;

  brCtlControl #(.SPECULATE(SPECULATE)) uCtl (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decOp(decOp),
    .memValid(memValid), .memOp(memOp), .memEqual(memEqual),
    .hazardStall(hazardStall), .strobe(strobe)
  );

  brCtlDatapath #(.PC_W(PC_W), .OFS_W(OFS_W)) uDp (
    .memPc(memPc), .memOffset(memOffset), .strobe(strobe),
    .redirectTarget(redirectTarget)
  );

  assign redirectValid = strobe.redirect;
  assign squashFetch   = strobe.sqFetch;
  assign squashDecode  = strobe.sqDecode;
  assign squashExecute = strobe.sqExecute;
  assign fetchHold     = strobe.fetchHold;
  assign decodeBubble  = strobe.decBubble;
  assign pipeStall     = strobe.pipeStall;
endmodule

// File: rtl/brRedirectChk.sv
module brRedirectChk #(
  parameter int PC_W      = 16,
  parameter int SPECULATE = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            memValid,
  input logic [2:0]      memOp,
  input logic            memEqual,
  input logic            redirectValid,
  input logic [PC_W-1:0] redirectTarget,
  input logic            squashFetch,
  input logic            squashDecode,
  input logic            squashExecute,
  input logic            fetchHold,
  input logic            decodeBubble,
  input logic            pipeStall
);
  assert_squash_needs_redirect_R2: assert property (@(posedge clk) disable iff (!rstN)
    (squashFetch || squashDecode || squashExecute) |-> redirectValid);

  assert_not_taken_free_R1: assert property (@(posedge clk) disable iff (!rstN)
    (SPECULATE != 0 && memValid && memOp == 3'd4 && !memEqual) |-> (!redirectValid && !squashFetch && !fetchHold));

  assert_jump_taken_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memOp == 3'd5) |-> redirectValid);

  assert_invalid_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> (!redirectValid && !squashExecute));

  assert_target_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |-> (redirectTarget == '0));

  assert_squash_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (!pipeStall && !fetchHold));

  assert_bubble_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    decodeBubble |-> fetchHold);

  assert_stall_mode_squash_R8: assert property (@(posedge clk) disable iff (!rstN)
    (SPECULATE == 0) |-> (!squashDecode && !squashExecute));
endmodule

bind branchRedirectCtl brRedirectChk #(.PC_W(PC_W), .SPECULATE(SPECULATE)) uChk (
  .clk(clk), .rstN(rstN), .memValid(memValid), .memOp(memOp), .memEqual(memEqual),
  .redirectValid(redirectValid), .redirectTarget(redirectTarget),
  .squashFetch(squashFetch), .squashDecode(squashDecode), .squashExecute(squashExecute),
  .fetchHold(fetchHold), .decodeBubble(decodeBubble), .pipeStall(pipeStall)
);

// File: tb/sim_branchRedirectCtl.sv
module sim_branchRedirectCtl;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;
  localparam int OFS_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 1'b0;
  logic [2:0] decOp = 3'd0;
  logic memValid = 1'b0;
  logic [2:0] memOp = 3'd0;
  logic memEqual = 1'b0;
  logic [PC_W-1:0] memPc = '0;
  logic [OFS_W-1:0] memOffset = '0;
  logic hazardStall = 1'b0;

  logic sRv, sSf, sSd, sSe, sFh, sDb, sPs;
  logic [PC_W-1:0] sTgt;
  logic tRv, tSf, tSd, tSe, tFh, tDb, tPs;
  logic [PC_W-1:0] tTgt;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branchRedirectCtl #(.PC_W(PC_W), .OFS_W(OFS_W), .SPECULATE(1)) u0 (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decOp(decOp),
    .memValid(memValid), .memOp(memOp), .memEqual(memEqual), .memPc(memPc),
    .memOffset(memOffset), .hazardStall(hazardStall),
    .redirectValid(sRv), .redirectTarget(sTgt), .squashFetch(sSf),
    .squashDecode(sSd), .squashExecute(sSe), .fetchHold(sFh),
    .decodeBubble(sDb), .pipeStall(sPs)
  );

  branchRedirectCtl #(.PC_W(PC_W), .OFS_W(OFS_W), .SPECULATE(0)) u1 (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decOp(decOp),
    .memValid(memValid), .memOp(memOp), .memEqual(memEqual), .memPc(memPc),
    .memOffset(memOffset), .hazardStall(hazardStall),
    .redirectValid(tRv), .redirectTarget(tTgt), .squashFetch(tSf),
    .squashDecode(tSd), .squashExecute(tSe), .fetchHold(tFh),
    .decodeBubble(tDb), .pipeStall(tPs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on falling edge, sample 1 time unit later (combinational outputs).
  task automatic drive(input logic dv, input logic [2:0] dop, input logic mv,
                       input logic [2:0] mop, input logic eq, input logic [15:0] pc,
                       input logic [7:0] ofs, input logic hz);
    @(negedge clk);
    decValid = dv; decOp = dop; memValid = mv; memOp = mop;
    memEqual = eq; memPc = pc; memOffset = ofs; hazardStall = hz;
    #1;
  endtask

  task automatic idle();
    drive(0, 3'd0, 0, 3'd0, 0, 16'h0, 8'h0, 0);
  endtask

  task automatic testReset();
    idle();
    check("R9 spec outputs", {sRv, sSf, sSd, sSe, sFh, sDb, sPs, 16'(sTgt)}, 0);
    check("R9 stall outputs", {tRv, tSf, tSd, tSe, tFh, tDb, tPs, 16'(tTgt)}, 0);
  endtask

  task automatic testNotTaken();
    drive(0, 3'd0, 1, 3'd4, 0, 16'h0040, 8'h05, 0);
    check("R1 no redirect", sRv, 0);
    check("R1 no squash", {sSf, sSd, sSe}, 0);
    check("R1 no hold", sFh, 0);
    idle();
  endtask

  task automatic testTaken();
    drive(0, 3'd0, 1, 3'd4, 1, 16'h0010, 8'hFE, 0);
    check("R2 redirect", sRv, 1);
    check("R2 squash all three", {sSf, sSd, sSe}, 3'b111);
    check("R3 negative offset target", sTgt, 16'h000F);
    drive(0, 3'd0, 1, 3'd4, 1, 16'h0100, 8'h20, 0);
    check("R3 positive offset target", sTgt, 16'h0121);
    drive(0, 3'd0, 1, 3'd4, 1, 16'hFFFF, 8'h01, 0);
    check("R3 wrap target", sTgt, 16'h0001);
    idle();
  endtask

  task automatic testJump();
    drive(0, 3'd0, 1, 3'd5, 0, 16'h0200, 8'h10, 0);
    check("R4 jump taken with eq=0", sRv, 1);
    check("R4 jump target", sTgt, 16'h0211);
    drive(0, 3'd0, 1, 3'd4, 1, 16'h0300, 8'h00, 0);
    check("R4 self compare taken", sRv, 1);
    idle();
  endtask

  task automatic testInvalid();
    drive(0, 3'd0, 0, 3'd4, 1, 16'h0050, 8'h07, 0);
    check("R5 squashed branch no redirect", {sRv, sSf, sSd, sSe}, 0);
    check("R5 target zero", sTgt, 0);
    drive(0, 3'd0, 1, 3'd2, 1, 16'h0050, 8'h07, 0);
    check("R5 non-branch opcode", {sRv, sSe}, 0);
    idle();
  endtask

  task automatic testPriority();
    drive(0, 3'd0, 1, 3'd4, 1, 16'h0010, 8'h02, 1);
    check("R6 squash beats stall pipeStall", sPs, 0);
    check("R6 squash beats stall fetchHold", sFh, 0);
    check("R6 redirect still", sRv, 1);
    drive(0, 3'd0, 0, 3'd0, 0, 16'h0, 8'h0, 1);
    check("R6 plain stall passes", {sPs, sFh}, 2'b11);
    idle();
  endtask

  task automatic testStallMode(input logic takenEq);
    // Cycle A: branch in decode
    drive(1, 3'd4, 0, 3'd0, 0, 16'h0, 8'h0, 0);
    check("R7 hold in decode cycle", {tFh, tDb}, 2'b11);
    // Cycle B: branch in execute
    drive(0, 3'd0, 0, 3'd0, 0, 16'h0, 8'h0, 0);
    check("R7 hold in execute cycle", {tFh, tDb}, 2'b11);
    // Cycle C: branch resolves
    drive(0, 3'd0, 1, 3'd4, takenEq, 16'h0080, 8'h03, 0);
    check("R7 release at resolve", {tFh, tDb}, 2'b00);
    check("R8 redirect and fetch squash", {tRv, tSf}, {takenEq, takenEq});
    check("R8 no decode/execute squash", {tSd, tSe}, 2'b00);
    if (takenEq) check("R3 stall mode target", tTgt, 16'h0084);
    // Cycle D: idle, window closed
    idle();
    check("R7 hold closed after resolve", {tFh, tDb}, 2'b00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rstN = 1'b1;
        testReset();
        testNotTaken();
        testTaken();
        testJump();
        testInvalid();
        testPriority();
        testStallMode(1'b1);
        testStallMode(1'b0);
        idle();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule